// File: doc/BRIEF.md
# Multi-Codec Serial Audio Port

This block is the clock master for a bank of stereo audio codecs. The codecs run from the same master clock as the block. From that clock the block makes one bit clock and one word (left/right) clock, and it shares both among all codecs. Every codec has its own serial line in each direction. In every frame the block shifts a left/right sample pair out on each codec's DAC line. In the same frame it collects a left/right pair from each codec's ADC line. It shows the collected pairs on parallel outputs together with a one-cycle strobe.

The master clock is 256 times the sample rate, so it is 12.288 MHz for 48 kHz or 11.2896 MHz for 44.1 kHz. Each channel slot is 32 bit clocks long. Framing can be right-justified or I2S, and the word width can be 16 or 24 bits. Both choices are made at run time and take effect only at a frame boundary. A loopback mode sends each codec's captured pair back to the same codec in the next frame. Codec register programming and mixing are done elsewhere.

Top module: `codec_bank_port`

## Requirements
- R1: `bclk` is the master clock divided by 4. It is high for 2 cycles and low for 2 cycles, and it rises every 4 cycles.
- R2: `lrclk` is low for the left slot and high for the right slot. Each slot is 32 bit periods (128 cycles). `lrclk` changes only in the cycle where `bclk` falls.
- R3: `sdout` changes only where `bclk` falls. `sdin` is sampled where `bclk` rises.
- R4: With `fmt_i2s`=0 (right-justified), each word is sent MSB first, and its LSB is at slot position 31, the last bit of the slot. Positions count from 0 at the word-clock change.
- R5: With `fmt_i2s`=1 (I2S), the MSB is at slot position 1, one bit period after the word-clock change, and the following bits come MSB first.
- R6: With `wide24`=1 the words are 24 bits, taken from tx bits [23:0]. With `wide24`=0 they are 16 bits, taken from tx bits [15:0]. Higher tx bits are ignored, `rx` bits above the width are 0, and `sdout` is 0 at every slot position outside the word.
- R7: Input bits at slot positions outside the word window are ignored. `rx_left`/`rx_right` hold only the bits taken at the positions that R4/R5 define.
- R8: `frame_valid` pulses high for one cycle every 256 cycles. It rises together with the `bclk` rise that samples the last bit of the right slot. `rx_left`/`rx_right` change only in that cycle.
- R9: `tx_left`, `tx_right`, `fmt_i2s`, `wide24` and `loopback` are sampled at the edge where `frame_valid` rises. They control the whole following frame. Changes at any other time have no effect.
- R10: With `loopback`=1 sampled, each codec sends in the next frame the pair it just captured, cut to the new width.
- R11: Each codec lane serialises and captures independently, using only its own bit slices of the tx/rx buses and its own `sdin`/`sdout` bit.
- R12: Reset clears `bclk`, `lrclk`, `sdout`, `frame_valid` and the rx outputs. The first frame after reset is right-justified 16-bit and carries zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256 x sample rate), also driven to the codecs |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| wide24 | input | 1 | Word width select: 0 for 16 bits, 1 for 24 bits |
| loopback | input | 1 | Send captured pairs back to the same codec |
| tx_left | input | NUM_CODECS*DW | Left words to send, codec c at bits [c*DW +: DW] |
| tx_right | input | NUM_CODECS*DW | Right words to send, same layout |
| sdin | input | NUM_CODECS | Serial ADC data, one bit per codec |
| bclk | output | 1 | Shared bit clock |
| lrclk | output | 1 | Shared word clock, low = left |
| sdout | output | NUM_CODECS | Serial DAC data, one bit per codec |
| rx_left | output | NUM_CODECS*DW | Captured left words |
| rx_right | output | NUM_CODECS*DW | Captured right words |
| frame_valid | output | 1 | One-cycle strobe when a new captured frame is present |

## Verification
Captured words and `frame_valid` are due at the master-clock edge where `bclk` rises for right-slot position 31. The bench waits for the strobe and reads the rx buses half a clock later, then reads them again 100 cycles later to confirm they have not changed. Serial bits change at the `bclk` fall, which comes two cycles before the sampling rise. The bench's codec model therefore drives `sdin` and records `sdout` one nanosecond after the bit-clock edges it sees on the ports. Settings applied just after a strobe are expected to show up only in the frame that starts after the next strobe, and loopback data one full frame after capture. Junk settings placed on the inputs during each frame check that nothing is sampled early.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // Framing selection for one frame.
  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } frame_fmt_e;

  // Settings latched at a frame boundary.
  typedef struct packed {
    frame_fmt_e fmt;
    logic       wide;
  } port_mode_t;

endpackage

// File: rtl/sport_timing.sv
// Bit-clock and word-clock generator. Both clocks are registered outputs
// made from enables in the master-clock domain.
module sport_timing #(
  parameter int CLK_PER_BIT = 4,
  parameter int SLOT_BITS   = 32,
  parameter int POS_W       = $clog2(2 * SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             frame_end,
  output logic [POS_W-1:0] drive_pos,
  output logic [POS_W-1:0] sample_pos
);

  localparam int PH_W = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;

  logic [PH_W-1:0]  ph;
  logic [POS_W-1:0] bitc;

  // The rise is half a bit period after the fall.
  assign rise_evt   = (ph == PH_W'(CLK_PER_BIT / 2 - 1));
  assign fall_evt   = (ph == PH_W'(CLK_PER_BIT - 1));
  assign sample_pos = bitc;
  assign drive_pos  = bitc + 1'b1;
  assign frame_end  = rise_evt && (bitc == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      bitc    <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else begin
      if (fall_evt) begin
        ph   <= '0;
        bitc <= bitc + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
      if (rise_evt) bclk_o <= 1'b1;
      if (fall_evt) begin
        bclk_o  <= 1'b0;
        lrclk_o <= drive_pos[POS_W-1];
      end
    end
  end

endmodule

// File: rtl/sport_lane.sv
// One codec lane: serialiser for the DAC line and deserialiser for the ADC line.
module sport_lane
  import sport_pkg::*;
#(
  parameter int DW        = 24,
  parameter int NW        = 16,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = $clog2(2 * SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_evt,
  input  logic             rise_evt,
  input  logic             frame_end,
  input  logic [POS_W-1:0] drive_pos,
  input  logic [POS_W-1:0] sample_pos,
  input  port_mode_t       mode,
  input  logic             loopback,
  input  logic [DW-1:0]    tx_l,
  input  logic [DW-1:0]    tx_r,
  input  logic             sdin,
  output logic             sdout,
  output logic [DW-1:0]    rx_l,
  output logic [DW-1:0]    rx_r
);

  localparam int SP_W = POS_W - 1;
  localparam int IW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [DW-1:0] NMASK = {{(DW - NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0]          hold_l, hold_r, left_cap;
  logic [SLOT_BITS-2:0]   shreg;
  logic [SLOT_BITS-1:0]   full;
  logic [DW-1:0]          right_now;

  function automatic logic [DW-1:0] keep(input logic [DW-1:0] w, input logic wide);
    return wide ? w : (w & NMASK);
  endfunction

  // Pull the word out of a whole slot as it was received.
  function automatic logic [DW-1:0] extract(input logic [SLOT_BITS-1:0] slot, input port_mode_t m);
    int nbits;
    int shamt;
    nbits = m.wide ? DW : NW;
    shamt = (m.fmt == FMT_I2S) ? (SLOT_BITS - 1 - nbits) : 0;
    return keep(DW'(slot >> shamt), m.wide);
  endfunction

  assign full      = {shreg, sdin};
  assign right_now = extract(full, mode);

  // Pick the outgoing bit for the slot position presented at the next fall.
  logic [SP_W-1:0] dp;
  logic [DW-1:0]   dword;
  int              nbits_tx;
  int              didx;
  logic            dbit;

  always_comb begin
    dp       = drive_pos[SP_W-1:0];
    dword    = drive_pos[POS_W-1] ? hold_r : hold_l;
    nbits_tx = mode.wide ? DW : NW;
    didx     = -1;
    if (mode.fmt == FMT_I2S) begin
      if (int'(dp) >= 1 && int'(dp) <= nbits_tx) didx = nbits_tx - int'(dp);
    end else if (int'(dp) >= SLOT_BITS - nbits_tx) begin
      didx = SLOT_BITS - 1 - int'(dp);
    end
    dbit = (didx >= 0 && didx < DW) ? dword[IW'(didx)] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdout    <= 1'b0;
      shreg    <= '0;
      left_cap <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      rx_l     <= '0;
      rx_r     <= '0;
    end else begin
      if (fall_evt) sdout <= dbit;
      if (rise_evt) begin
        shreg <= full[SLOT_BITS-2:0];
        if (sample_pos == POS_W'(SLOT_BITS - 1)) left_cap <= extract(full, mode);
      end
      if (frame_end) begin
        rx_l   <= left_cap;
        rx_r   <= right_now;
        hold_l <= loopback ? left_cap  : tx_l;
        hold_r <= loopback ? right_now : tx_r;
      end
    end
  end

endmodule

// File: rtl/codec_bank_port.sv
// Clock-master serial port for a bank of stereo codecs that share one set of clocks.
module codec_bank_port
  import sport_pkg::*;
#(
  parameter int NUM_CODECS  = 8,
  parameter int DW          = 24,
  parameter int NW          = 16,
  parameter int SLOT_BITS   = 32,
  parameter int CLK_PER_BIT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fmt_i2s,
  input  logic                     wide24,
  input  logic                     loopback,
  input  logic [NUM_CODECS*DW-1:0] tx_left,
  input  logic [NUM_CODECS*DW-1:0] tx_right,
  input  logic [NUM_CODECS-1:0]    sdin,
  output logic                     bclk,
  output logic                     lrclk,
  output logic [NUM_CODECS-1:0]    sdout,
  output logic [NUM_CODECS*DW-1:0] rx_left,
  output logic [NUM_CODECS*DW-1:0] rx_right,
  output logic                     frame_valid
);

  localparam int POS_W = $clog2(2 * SLOT_BITS);

  logic             fall_evt, rise_evt, frame_end;
  logic [POS_W-1:0] drive_pos, sample_pos;
  port_mode_t       mode_q;

  sport_timing #(
    .CLK_PER_BIT(CLK_PER_BIT),
    .SLOT_BITS  (SLOT_BITS),
    .POS_W      (POS_W)
  ) timing_i (
    .clk       (clk),
    .rst       (rst),
    .bclk_o    (bclk),
    .lrclk_o   (lrclk),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .frame_end (frame_end),
    .drive_pos (drive_pos),
    .sample_pos(sample_pos)
  );

  // Framing and width change only at a frame boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= '{fmt: FMT_RJ, wide: 1'b0};
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= frame_end;
      if (frame_end) mode_q <= '{fmt: frame_fmt_e'(fmt_i2s), wide: wide24};
    end
  end

  for (genvar c = 0; c < NUM_CODECS; c++) begin : g_lane
    sport_lane #(
      .DW       (DW),
      .NW       (NW),
      .SLOT_BITS(SLOT_BITS),
      .POS_W    (POS_W)
    ) lane_i (
      .clk       (clk),
      .rst       (rst),
      .fall_evt  (fall_evt),
      .rise_evt  (rise_evt),
      .frame_end (frame_end),
      .drive_pos (drive_pos),
      .sample_pos(sample_pos),
      .mode      (mode_q),
      .loopback  (loopback),
      .tx_l      (tx_left[c*DW +: DW]),
      .tx_r      (tx_right[c*DW +: DW]),
      .sdin      (sdin[c]),
      .sdout     (sdout[c]),
      .rx_l      (rx_left[c*DW +: DW]),
      .rx_r      (rx_right[c*DW +: DW])
    );
  end

endmodule

// File: rtl/codec_bank_port_chk.sv
module codec_bank_port_chk #(
  parameter int NUM_CODECS = 8,
  parameter int DW         = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bclk,
  input logic                     lrclk,
  input logic [NUM_CODECS-1:0]    sdout,
  input logic [NUM_CODECS*DW-1:0] rx_left,
  input logic [NUM_CODECS*DW-1:0] rx_right,
  input logic                     frame_valid
);

  assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk));

  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $fell(bclk));

  assert_strobe_at_right_rise_R8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> ($rose(bclk) && lrclk));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(rx_left) && $stable(rx_right)));

endmodule

bind codec_bank_port codec_bank_port_chk #(
  .NUM_CODECS(NUM_CODECS),
  .DW        (DW)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bclk       (bclk),
  .lrclk      (lrclk),
  .sdout      (sdout),
  .rx_left    (rx_left),
  .rx_right   (rx_right),
  .frame_valid(frame_valid)
);

// File: tb/codec_bank_port_tb_top.sv
module codec_bank_port_tb_top;
  localparam int N      = 8;
  localparam int DW     = 24;
  localparam int NW     = 16;
  localparam int SLOT   = 32;
  localparam int FRAMES = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            fmt_i2s, wide24, loopback;
  logic [N*DW-1:0] tx_left, tx_right;
  logic [N-1:0]    sdin = '0;
  logic            bclk, lrclk, frame_valid;
  logic [N-1:0]    sdout;
  logic [N*DW-1:0] rx_left, rx_right;

  codec_bank_port #(.NUM_CODECS(N), .DW(DW), .NW(NW), .SLOT_BITS(SLOT), .CLK_PER_BIT(4)) dut_i (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .wide24(wide24), .loopback(loopback),
    .tx_left(tx_left), .tx_right(tx_right), .sdin(sdin), .bclk(bclk), .lrclk(lrclk),
    .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right), .frame_valid(frame_valid)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] w, input bit wide);
    return wide ? w : {{(DW - NW){1'b0}}, w[NW-1:0]};
  endfunction

  // Word bit carried at slot position p, or -1 when p lies outside the word (R4, R5, R6).
  function automatic int slot_index(input int p, input bit i2s, input bit wide);
    int nb;
    nb = wide ? DW : NW;
    if (i2s) return (p >= 1 && p <= nb) ? nb - p : -1;
    return (p >= SLOT - nb) ? SLOT - 1 - p : -1;
  endfunction

  // ---------------- codec model ----------------
  logic [DW-1:0] cur_l [N] = '{default: '0};
  logic [DW-1:0] cur_r [N] = '{default: '0};
  logic [DW-1:0] nxt_l [N] = '{default: '0};
  logic [DW-1:0] nxt_r [N] = '{default: '0};
  logic [DW-1:0] done_l [N];
  logic [DW-1:0] done_r [N];
  logic [DW-1:0] got_l [N];
  logic [DW-1:0] got_r [N];
  int            stray [N];
  logic          rec [N][2][SLOT];
  bit cur_i2s = 1'b0, cur_wide = 1'b0, nxt_i2s = 1'b0, nxt_wide = 1'b0;
  int pos = 0;
  bit prev_lr = 1'b0;

  always @(negedge bclk) begin
    #1;
    if (lrclk != prev_lr) begin
      pos = 0;
      prev_lr = lrclk;
      if (!lrclk) begin
        cur_l = nxt_l;
        cur_r = nxt_r;
        cur_i2s = nxt_i2s;
        cur_wide = nxt_wide;
      end
    end else begin
      pos++;
    end
    for (int c = 0; c < N; c++) begin
      int idx;
      logic [DW-1:0] w;
      idx = slot_index(pos, cur_i2s, cur_wide);
      w = lrclk ? cur_r[c] : cur_l[c];
      // R7: positions outside the word carry random junk
      sdin[c] = (idx >= 0) ? w[idx] : 1'($urandom_range(0, 1));
    end
  end

  always @(posedge bclk) begin
    #1;
    for (int c = 0; c < N; c++) rec[c][lrclk][pos] = sdout[c];
    if (lrclk && pos == SLOT - 1) begin
      for (int c = 0; c < N; c++) begin
        got_l[c] = '0;
        got_r[c] = '0;
        stray[c] = 0;
        for (int p = 0; p < SLOT; p++) begin
          int idx;
          idx = slot_index(p, cur_i2s, cur_wide);
          if (idx >= 0) begin
            got_l[c][idx] = rec[c][0][p];
            got_r[c][idx] = rec[c][1][p];
          end else begin
            if (rec[c][0][p]) stray[c]++;
            if (rec[c][1][p]) stray[c]++;
          end
        end
        done_l[c] = cur_l[c];
        done_r[c] = cur_r[c];
      end
    end
  end

  // ---------------- clock monitor (R1, R2, R3) ----------------
  int last_rise = -1, last_lr = -1;
  bit pb = 1'b0, plr = 1'b0;
  logic [N-1:0] psd = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bclk && !pb) begin
        if (last_rise >= 0) check(cyc - last_rise == 4, "R1", "bit clock period", cyc - last_rise, 4);
        last_rise = cyc;
      end
      if (lrclk != plr) begin
        check(pb && !bclk, "R2", "word clock moved off a bit clock fall", {30'b0, pb, bclk}, 2);
        if (last_lr >= 0) check(cyc - last_lr == 128, "R2", "word clock half period", cyc - last_lr, 128);
        last_lr = cyc;
      end
      if (sdout != psd) check(pb && !bclk, "R3", "serial data moved off a bit clock fall", {30'b0, pb, bclk}, 2);
    end
    pb = bclk;
    plr = lrclk;
    psd = sdout;
  end

  // ---------------- stimulus and frame checks ----------------
  bit p_i2s, p_wide, p_loop;
  logic [DW-1:0] p_l [N];
  logic [DW-1:0] p_r [N];
  logic [DW-1:0] exp_l [N] = '{default: '0};
  logic [DW-1:0] exp_r [N] = '{default: '0};
  bit e_i2s = 1'b0, e_wide = 1'b0, e_loop = 1'b0;

  task automatic pick(input int k);
    case (k % 8)
      0: begin p_i2s = 0; p_wide = 0; p_loop = 0; end
      1: begin p_i2s = 0; p_wide = 1; p_loop = 0; end
      2: begin p_i2s = 1; p_wide = 0; p_loop = 0; end
      3: begin p_i2s = 1; p_wide = 1; p_loop = 0; end
      4: begin p_i2s = 0; p_wide = 1; p_loop = 1; end
      5: begin p_i2s = 1; p_wide = 0; p_loop = 1; end
      default: begin
        p_i2s = 1'($urandom_range(0, 1));
        p_wide = 1'($urandom_range(0, 1));
        p_loop = 1'($urandom_range(0, 1));
      end
    endcase
    for (int c = 0; c < N; c++) begin
      case (k % 5)
        0: begin p_l[c] = '1; p_r[c] = '1; end
        1: begin p_l[c] = {1'b1, {(DW - 1){1'b0}}}; p_r[c] = DW'(1); end
        2: begin p_l[c] = DW'(1); p_r[c] = {1'b1, {(DW - 1){1'b0}}}; end
        default: begin p_l[c] = DW'($urandom); p_r[c] = DW'($urandom); end
      endcase
      tx_left[c*DW +: DW] = p_l[c];
      tx_right[c*DW +: DW] = p_r[c];
    end
    fmt_i2s = p_i2s;
    wide24 = p_wide;
    loopback = p_loop;
  endtask

  initial begin
    int last_fv;
    logic [N*DW-1:0] snap_l, snap_r;
    void'($urandom(32'd1234));
    fmt_i2s = 0; wide24 = 0; loopback = 0; tx_left = '0; tx_right = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(bclk == 0 && lrclk == 0, "R12", "clocks in reset", {30'b0, bclk, lrclk}, 0);
    check(sdout == '0, "R12", "sdout in reset", 32'(sdout), 0);
    check(frame_valid == 0, "R12", "strobe in reset", 32'(frame_valid), 0);
    check(rx_left == '0 && rx_right == '0, "R12", "rx in reset", 32'(rx_left[31:0]), 0);
    pick(1);
    rst = 0;
    last_fv = -1;
    for (int k = 0; k < FRAMES; k++) begin
      do @(negedge clk); while (!frame_valid);
      if (last_fv >= 0) check(cyc - last_fv == 256, "R8", "strobe spacing", cyc - last_fv, 256);
      last_fv = cyc;
      // R11: every lane is compared on its own slices
      for (int c = 0; c < N; c++) begin
        check(rx_left[c*DW +: DW] == trim(done_l[c], e_wide), "R7", $sformatf("rx left lane %0d", c),
              32'(rx_left[c*DW +: DW]), 32'(trim(done_l[c], e_wide)));
        check(rx_right[c*DW +: DW] == trim(done_r[c], e_wide), "R7", $sformatf("rx right lane %0d", c),
              32'(rx_right[c*DW +: DW]), 32'(trim(done_r[c], e_wide)));
        check(got_l[c] == exp_l[c], e_loop ? "R10" : (e_i2s ? "R5" : "R4"), $sformatf("sent left lane %0d", c),
              32'(got_l[c]), 32'(exp_l[c]));
        check(got_r[c] == exp_r[c], e_loop ? "R10" : (e_i2s ? "R5" : "R4"), $sformatf("sent right lane %0d", c),
              32'(got_r[c]), 32'(exp_r[c]));
        check(stray[c] == 0, "R6", $sformatf("ones outside word lane %0d", c), stray[c], 0);
      end
      // R9: settings sampled at this strobe decide the next frame
      for (int c = 0; c < N; c++) begin
        exp_l[c] = p_loop ? trim(trim(done_l[c], e_wide), p_wide) : trim(p_l[c], p_wide);
        exp_r[c] = p_loop ? trim(trim(done_r[c], e_wide), p_wide) : trim(p_r[c], p_wide);
        nxt_l[c] = DW'($urandom);
        nxt_r[c] = DW'($urandom);
      end
      e_i2s = p_i2s; e_wide = p_wide; e_loop = p_loop;
      nxt_i2s = p_i2s; nxt_wide = p_wide;
      snap_l = rx_left; snap_r = rx_right;
      // junk settings during the frame must have no effect (R9)
      fmt_i2s = ~p_i2s; wide24 = ~p_wide; loopback = ~p_loop;
      for (int c = 0; c < N; c++) begin
        tx_left[c*DW +: DW] = DW'($urandom);
        tx_right[c*DW +: DW] = DW'($urandom);
      end
      @(negedge clk);
      check(frame_valid == 0, "R8", "strobe width", 32'(frame_valid), 0);
      repeat (100) @(negedge clk);
      check(rx_left == snap_l && rx_right == snap_r, "R8", "rx held between strobes",
            32'(rx_left[31:0]), 32'(snap_l[31:0]));
      pick(k + 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected run to complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule